// File: doc/BRIEF.md
# Interrupt Flag and Enable Aggregator

This block collects eight peripheral interrupt sources into a single request line for the CPU interrupt controller. Each source has a pending flag and an enable bit. Both are held in one 16-bit status/mask register that software reads and writes over a simple register bus. The interrupt output is high whenever at least one source is both pending and enabled.

Software can change the register in three ways. A direct write replaces all sixteen bits. Two write-only alias addresses give atomic access to individual bits: one sets every bit written as 1, the other clears every bit written as 1, and bits written as 0 are left alone. Hardware event pulses from the peripherals set the matching flag bits. A hardware event that lands in the same cycle as a software clear of that flag wins, so no event is lost. Source 0 is spare. Sources 1 to 7 serve, in order: two-wire serial transmit, two-wire serial receive, synchronous serial transmit, synchronous serial receive, asynchronous serial transmit-buffer-empty, asynchronous serial transmit and asynchronous serial receive.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status/mask register reads 0000h and `irq_o` is low.
- R2: The register layout is bits 15:8 for the enables (bit 8+i enables source i) and bits 7:0 for the flags (bit i is the flag of source i). A write to address 0 replaces all 16 bits, and the new value is visible from the next cycle.
- R3: A write to address 1 (set alias) sets every register bit whose write-data bit is 1. Every other bit keeps its value.
- R4: A write to address 2 (clear alias) clears every register bit whose write-data bit is 1. Every other bit keeps its value.
- R5: When `evt_i[i]` is high at a clock edge, flag bit i is 1 after that edge. Enable bits are never changed by events.
- R6: An event on source i in the same cycle as a clear-alias write or a direct write that would zero flag i leaves flag i set.
- R7: `irq_o` is high exactly when some i has both flag bit i and enable bit 8+i equal to 1. It follows the register combinationally.
- R8: Reads of address 0 return the register. Reads of addresses 1, 2 and 3 return 0000h. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address: 0 = register, 1 = set alias, 2 = clear alias |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for addr_i |
| evt_i | input | 8 | Peripheral event pulses, one per source |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives random mixes of direct, set and clear writes with random event vectors. It deliberately includes cases where an event and a clear of the same flag fall in the same cycle. A design with the priority backwards would drop that flag and miss an interrupt.

It checks that 0 bits in alias writes leave the register untouched. A design that treated the aliases as plain writes would wipe bits that were not targeted. It also confirms that events never touch the enable half, and that the alias addresses read back as zero rather than mirroring the register.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [2*NSRC-1:0] wdata_i,
  output logic [2*NSRC-1:0] rdata_o,
  input  logic [NSRC-1:0]   evt_i,
  output logic              irq_o
);
  localparam int W = 2 * NSRC;

  logic [W-1:0] sel_q, sel_sw, sel_d;

  always_comb begin
    sel_sw = sel_q;
    if (we_i) begin
      case (addr_i)
        2'd0:    sel_sw = wdata_i;
        2'd1:    sel_sw = sel_q | wdata_i;
        2'd2:    sel_sw = sel_q & ~wdata_i;
        default: sel_sw = sel_q;
      endcase
    end
  end

  assign sel_d = sel_sw | {{NSRC{1'b0}}, evt_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_d;

  assign rdata_o = (addr_i == 2'd0) ? sel_q : '0;
  assign irq_o   = |(sel_q[W-1:NSRC] & sel_q[NSRC-1:0]);

  assert_event_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((sel_q[NSRC-1:0] & $past(evt_i)) == $past(evt_i)));

  assert_event_keeps_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i) |=> (sel_q[W-1:NSRC] == $past(sel_q[W-1:NSRC])));

  assert_clear_loses_to_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd2 && (wdata_i[NSRC-1:0] & evt_i) != '0)
      |=> ((sel_q[NSRC-1:0] & $past(evt_i)) == $past(evt_i)));

  assert_set_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1) |=> ((sel_q & $past(wdata_i)) == $past(wdata_i)));

  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(we_i && addr_i != 2'd3) && evt_i == '0) |=> $stable(sel_q));

  assert_alias_read_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != 2'd0) |-> (rdata_o == '0));

  assert_irq_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q[W-1:NSRC] == '0) |-> !irq_o);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic clk = 0, rst_n = 0, we = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [7:0] evt = 0;
  logic irq;
  int checks = 0, fails = 0;
  int model = 0;

  always #2 clk = ~clk;

  irq_aggregator u_dut (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: one clock step
  function automatic int step(int m, bit w, int a, int d, int e);
    int n = m;
    if (w) begin
      if (a == 0) n = d;
      else if (a == 1) n = m | d;
      else if (a == 2) n = m & ~d;
    end
    for (int i = 0; i < 8; i++) if (e[i]) n = n | (1 << i);
    return n & 16'hFFFF;
  endfunction

  function automatic int irq_of(int m);
    return (((m >> 8) & m & 8'hFF) != 0) ? 1 : 0;
  endfunction

  task automatic drive(bit w, int a, int d, int e, string req);
    we = w; addr = a[1:0]; wdata = d[15:0]; evt = e[7:0];
    @(posedge clk);
    model = step(model, w, a, d, e);
    #1;
    we = 0; evt = 0; addr = 0;
    #0.5;
    chk(req, rdata, model);
    chk("R7", irq, irq_of(model));
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", rdata, 0);
    chk("R1", irq, 0);
    rst_n = 1;
    drive(1, 0, 16'h0F05, 0, "R2");
    drive(1, 1, 16'h3002, 0, "R3");
    drive(1, 2, 16'h0104, 0, "R4");
    drive(0, 0, 0, 8'h80, "R5");
    drive(1, 2, 16'h0082, 8'h80, "R6");
    drive(1, 0, 16'hFF00, 8'h01, "R6");
    drive(1, 3, 16'hFFFF, 0, "R8");
    drive(1, 2, 16'hFFFF, 0, "R4");
    drive(0, 0, 0, 8'hFF, "R5");
    drive(1, 1, 16'hA500, 0, "R7");
    addr = 1; #0.5; chk("R8", rdata, 0);
    addr = 2; #0.5; chk("R8", rdata, 0);
    addr = 3; #0.5; chk("R8", rdata, 0);
    addr = 0;
    for (int k = 0; k < 400; k++)
      drive($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 16'hFFFF),
            ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : 0, "R3/R4/R6 random");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule